// File: doc/BRIEF.md
# Multi-thread gate control schedule engine

This block is a time-aware egress gate scheduler. A single table of timeslots is shared by up to eight cyclic execution threads. Each timeslot holds three things: a duration in delta units, a mask of destination ports, and a mask of traffic classes to block. Each thread owns a contiguous range of the table. It wakes up when a free-running time value reaches the programmed schedule start time plus that thread's own entry offset. It then plays its timeslots in order and wraps back to its first slot. The block merges the active slots of all threads into one open/closed vector per port.

Software loads the table, the thread settings and the global settings while the engine is stopped, then issues a start command. The engine validates the whole configuration when the start command arrives. If the configuration is bad, the start is refused. A stop command halts every thread and opens every gate.

Engine states:
- STOPPED: idle; configuration writes are allowed. A start with a valid configuration moves to ARMED. A start with a bad configuration stays here and raises the bad-configuration flag.
- ARMED: threads are waiting for their begin times. The first thread that begins moves the engine to RUNNING.
- RUNNING: at least one thread is playing slots.
- A stop command from ARMED or RUNNING returns to STOPPED.

Thread states:
- IDLE: on an accepted start, an in-use thread moves to WAIT.
- WAIT: when the time value reaches the thread's begin time, the thread moves to ACTIVE.
- ACTIVE: the thread walks its slots.
- Stop returns every thread to IDLE.

Top module: `gate_sched_engine`

## Requirements
- R1: After reset, `gate_open` is all ones, `sts_stopped`=1, `sts_started`=0, `wr_err`=0 and `cfg_bad`=0.
- R2: `glb_active_m1` selects how many threads are in use: threads 0 to `glb_active_m1`. Threads above that number never run, and their offset and entry values are not validated.
- R3: An in-use thread begins at the first clock edge at which `now_time` >= start time + its offset (unsigned compare). The gates show its entry slot from the cycle after that edge.
- R4: A thread plays slots from its entry index up to its end index, one after another. After the end index it wraps to the entry index.
- R5: A slot lasts duration x TICKS_PER_DELTA `tick` strobes (default 25 strobes per delta). While `tick` is low the thread holds its slot, and its gate contribution is unchanged.
- R6: A start is refused when any in-use thread has an offset of zero. The engine stays STOPPED and `cfg_bad` becomes 1 the next cycle.
- R7: A start is refused in the same way when any slot from index 0 up to the end index of the last in-use thread has a duration of 0 or a duration >= MAX_DELTA (default 1000).
- R8: A start is refused in the same way in two cases: an end index falls from thread i to thread i+1 (checked over all eight threads), or an in-use thread has its entry index above its end index.
- R9: Bit p*8+c of `gate_open` is class c of port p, and 1 means open. An active slot whose port-mask bit p is set closes the classes whose bits are set in its block mask. Closures from several threads are ORed together. A port that no active slot targets is fully open.
- R10: An accepted start gives `sts_started`=0 and `sts_stopped`=0 (ARMED). `sts_started` rises one cycle after the first thread begins. A stop gives `sts_stopped`=1, `sts_started`=0 and all gates open on the next cycle.
- R11: A write (slot, thread or global) is refused when the engine is not STOPPED, or when it falls in the cycle of a start command. A refused write changes nothing, and `wr_err` is 1 for exactly the next cycle. An accepted write leaves `wr_err` at 0.
- R12: An accepted start clears `cfg_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Scheduler tick strobe |
| now_time | input | TIME_W | Free-running time value |
| start_cmd | input | 1 | Start command |
| stop_cmd | input | 1 | Stop command |
| slot_we | input | 1 | Timeslot write enable |
| slot_addr | input | IDX_W | Timeslot index |
| slot_dur | input | DUR_W | Timeslot duration in deltas |
| slot_ports | input | NUM_PORTS | Destination-port mask |
| slot_block | input | NUM_TC | Classes to block |
| thr_we | input | 1 | Thread write enable |
| thr_sel | input | THR_W | Thread number |
| thr_entry | input | IDX_W | Entry index of the thread |
| thr_end | input | IDX_W | End index of the thread |
| thr_ofs | input | TIME_W | Begin offset from the start time |
| glb_we | input | 1 | Global write enable |
| glb_start_time | input | TIME_W | Schedule start time |
| glb_active_m1 | input | THR_W | Number of in-use threads minus one |
| gate_open | output | NUM_PORTS*NUM_TC | Per-port, per-class gate state, 1 = open |
| sts_started | output | 1 | Engine running |
| sts_stopped | output | 1 | Engine stopped |
| wr_err | output | 1 | A write was refused last cycle |
| cfg_bad | output | 1 | Last start was refused for a bad configuration |

## Verification
The slot-range and hold assertions assume that thread settings and slot durations do not change while a thread is active. The configuration assertion assumes the same while the engine is out of STOPPED. The design enforces both by refusing writes, so the stimulus freely attempts a write mid-run without breaking them. The bench keeps every start time well ahead of the current time. The time value never wraps, so each begin-time comparison is a plain unsigned one. The tick strobe stays high except in one deliberate stall window.

// File: rtl/gse_pkg.sv
package gse_pkg;
    typedef enum logic [1:0] {
        ENG_STOPPED = 2'd0,
        ENG_ARMED   = 2'd1,
        ENG_RUNNING = 2'd2
    } eng_state_t;

    typedef enum logic [1:0] {
        THR_IDLE   = 2'd0,
        THR_WAIT   = 2'd1,
        THR_ACTIVE = 2'd2
    } thr_state_t;
endpackage

// File: rtl/gse_cfg_store.sv
module gse_cfg_store #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 16,
    parameter int NUM_PORTS   = 4,
    parameter int NUM_TC      = 8,
    parameter int TIME_W      = 32,
    parameter int DUR_W       = 10,
    parameter int IDX_W       = 4,
    parameter int THR_W       = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_allow,
    input  logic                 slot_we,
    input  logic [IDX_W-1:0]     slot_addr,
    input  logic [DUR_W-1:0]     slot_dur,
    input  logic [NUM_PORTS-1:0] slot_ports,
    input  logic [NUM_TC-1:0]    slot_block,
    input  logic                 thr_we,
    input  logic [THR_W-1:0]     thr_sel,
    input  logic [IDX_W-1:0]     thr_entry,
    input  logic [IDX_W-1:0]     thr_end,
    input  logic [TIME_W-1:0]    thr_ofs,
    input  logic                 glb_we,
    input  logic [TIME_W-1:0]    glb_start_time,
    input  logic [THR_W-1:0]     glb_active_m1,
    output logic [DUR_W-1:0]     dur_tab   [NUM_SLOTS],
    output logic [NUM_PORTS-1:0] port_tab  [NUM_SLOTS],
    output logic [NUM_TC-1:0]    blk_tab   [NUM_SLOTS],
    output logic [IDX_W-1:0]     entry_tab [NUM_THREADS],
    output logic [IDX_W-1:0]     end_tab   [NUM_THREADS],
    output logic [TIME_W-1:0]    ofs_tab   [NUM_THREADS],
    output logic [TIME_W-1:0]    start_time,
    output logic [THR_W-1:0]     active_m1,
    output logic                 wr_rej
);
    logic any_we;
    assign any_we = slot_we | thr_we | glb_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                dur_tab[s]  <= '0;
                port_tab[s] <= '0;
                blk_tab[s]  <= '0;
            end
            for (int t = 0; t < NUM_THREADS; t++) begin
                entry_tab[t] <= '0;
                end_tab[t]   <= '0;
                ofs_tab[t]   <= '0;
            end
            start_time <= '0;
            active_m1  <= '0;
            wr_rej     <= 1'b0;
        end else begin
            wr_rej <= any_we && !wr_allow;
            if (wr_allow && slot_we) begin
                dur_tab[slot_addr]  <= slot_dur;
                port_tab[slot_addr] <= slot_ports;
                blk_tab[slot_addr]  <= slot_block;
            end
            if (wr_allow && thr_we) begin
                entry_tab[thr_sel] <= thr_entry;
                end_tab[thr_sel]   <= thr_end;
                ofs_tab[thr_sel]   <= thr_ofs;
            end
            if (wr_allow && glb_we) begin
                start_time <= glb_start_time;
                active_m1  <= glb_active_m1;
            end
        end
    end
endmodule

// File: rtl/gse_cfg_check.sv
module gse_cfg_check #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 16,
    parameter int TIME_W      = 32,
    parameter int DUR_W       = 10,
    parameter int IDX_W       = 4,
    parameter int THR_W       = 3,
    parameter int MAX_DELTA   = 1000
) (
    input  logic [DUR_W-1:0]  dur_tab   [NUM_SLOTS],
    input  logic [IDX_W-1:0]  entry_tab [NUM_THREADS],
    input  logic [IDX_W-1:0]  end_tab   [NUM_THREADS],
    input  logic [TIME_W-1:0] ofs_tab   [NUM_THREADS],
    input  logic [THR_W-1:0]  active_m1,
    output logic              cfg_ok
);
    logic [IDX_W-1:0] last_end;
    logic             order_ok;
    logic             thread_ok;
    logic             slot_ok;

    assign last_end = end_tab[active_m1];

    // end indices never fall, over every thread in use or not
    always_comb begin
        order_ok = 1'b1;
        for (int t = 1; t < NUM_THREADS; t++) begin
            if (end_tab[t] < end_tab[t-1]) order_ok = 1'b0;
        end
    end

    // per-thread legality, only for threads in use
    always_comb begin
        thread_ok = 1'b1;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (t <= int'(active_m1)) begin
                if (ofs_tab[t] == '0) thread_ok = 1'b0;
                if (entry_tab[t] > end_tab[t]) thread_ok = 1'b0;
            end
        end
    end

    // durations of every slot that some thread may reach
    always_comb begin
        slot_ok = 1'b1;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (s <= int'(last_end)) begin
                if (dur_tab[s] == '0) slot_ok = 1'b0;
                if (int'(dur_tab[s]) >= MAX_DELTA) slot_ok = 1'b0;
            end
        end
    end

    assign cfg_ok = order_ok && thread_ok && slot_ok;
endmodule

// File: rtl/gse_thread.sv
module gse_thread
    import gse_pkg::*;
#(
    parameter int IDX_W           = 4,
    parameter int TIME_W          = 32,
    parameter int DUR_W           = 10,
    parameter int TICKS_PER_DELTA = 25,
    localparam int TCK_W = (TICKS_PER_DELTA > 1) ? $clog2(TICKS_PER_DELTA) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              halt,
    input  logic              enable,
    input  logic              tick,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] begin_time,
    input  logic [IDX_W-1:0]  entry_idx,
    input  logic [IDX_W-1:0]  end_idx,
    input  logic [DUR_W-1:0]  cur_dur,
    output logic              active,
    output logic [IDX_W-1:0]  cur_idx
);
    thr_state_t       st_q, st_d;
    logic [TCK_W-1:0] tcnt;
    logic [DUR_W-1:0] dcnt;
    logic             delta_end;
    logic             slot_end;

    assign delta_end = tick && (tcnt == TCK_W'(TICKS_PER_DELTA - 1));
    assign slot_end  = delta_end && (dcnt == cur_dur - DUR_W'(1));

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            THR_IDLE:   if (arm && enable) st_d = THR_WAIT;
            THR_WAIT:   if (now_time >= begin_time) st_d = THR_ACTIVE;
            THR_ACTIVE: st_d = THR_ACTIVE;
            default:    st_d = THR_IDLE;
        endcase
        if (halt) st_d = THR_IDLE;
    end

    // state register and slot walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= THR_IDLE;
            cur_idx <= '0;
            tcnt    <= '0;
            dcnt    <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == THR_WAIT && st_d == THR_ACTIVE) begin
                cur_idx <= entry_idx;
                tcnt    <= '0;
                dcnt    <= '0;
            end else if (st_q == THR_ACTIVE && st_d == THR_ACTIVE && tick) begin
                if (delta_end) begin
                    tcnt <= '0;
                    if (slot_end) begin
                        dcnt    <= '0;
                        cur_idx <= (cur_idx == end_idx) ? entry_idx : cur_idx + 1'b1;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        active = 1'b0;
        unique case (st_q)
            THR_IDLE:   active = 1'b0;
            THR_WAIT:   active = 1'b0;
            THR_ACTIVE: active = 1'b1;
            default:    active = 1'b0;
        endcase
    end

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cur_idx >= entry_idx && cur_idx <= end_idx));

    // R5
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(cur_idx));

    // R10
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !active);
endmodule

// File: rtl/gse_gate_merge.sv
module gse_gate_merge #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 16,
    parameter int NUM_PORTS   = 4,
    parameter int NUM_TC      = 8,
    parameter int IDX_W       = 4,
    localparam int GATE_W = NUM_PORTS * NUM_TC
) (
    input  logic [NUM_THREADS-1:0] thr_active,
    input  logic [IDX_W-1:0]       thr_idx  [NUM_THREADS],
    input  logic [NUM_PORTS-1:0]   port_tab [NUM_SLOTS],
    input  logic [NUM_TC-1:0]      blk_tab  [NUM_SLOTS],
    output logic [GATE_W-1:0]      gate_open
);
    logic [NUM_TC-1:0] closed [NUM_PORTS];

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) closed[p] = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (thr_active[t]) begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (port_tab[thr_idx[t]][p]) closed[p] = closed[p] | blk_tab[thr_idx[t]];
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign gate_open[p*NUM_TC +: NUM_TC] = ~closed[p];
    end
endmodule

// File: rtl/gate_sched_engine.sv
module gate_sched_engine
    import gse_pkg::*;
#(
    parameter int NUM_THREADS     = 8,
    parameter int NUM_SLOTS       = 16,
    parameter int NUM_PORTS       = 4,
    parameter int NUM_TC          = 8,
    parameter int TIME_W          = 32,
    parameter int DUR_W           = 10,
    parameter int TICKS_PER_DELTA = 25,
    parameter int MAX_DELTA       = 1000,
    localparam int IDX_W  = $clog2(NUM_SLOTS),
    localparam int THR_W  = $clog2(NUM_THREADS),
    localparam int GATE_W = NUM_PORTS * NUM_TC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [TIME_W-1:0]    now_time,
    input  logic                 start_cmd,
    input  logic                 stop_cmd,
    input  logic                 slot_we,
    input  logic [IDX_W-1:0]     slot_addr,
    input  logic [DUR_W-1:0]     slot_dur,
    input  logic [NUM_PORTS-1:0] slot_ports,
    input  logic [NUM_TC-1:0]    slot_block,
    input  logic                 thr_we,
    input  logic [THR_W-1:0]     thr_sel,
    input  logic [IDX_W-1:0]     thr_entry,
    input  logic [IDX_W-1:0]     thr_end,
    input  logic [TIME_W-1:0]    thr_ofs,
    input  logic                 glb_we,
    input  logic [TIME_W-1:0]    glb_start_time,
    input  logic [THR_W-1:0]     glb_active_m1,
    output logic [GATE_W-1:0]    gate_open,
    output logic                 sts_started,
    output logic                 sts_stopped,
    output logic                 wr_err,
    output logic                 cfg_bad
);
    eng_state_t state_q, state_d;

    logic [DUR_W-1:0]     dur_tab   [NUM_SLOTS];
    logic [NUM_PORTS-1:0] port_tab  [NUM_SLOTS];
    logic [NUM_TC-1:0]    blk_tab   [NUM_SLOTS];
    logic [IDX_W-1:0]     entry_tab [NUM_THREADS];
    logic [IDX_W-1:0]     end_tab   [NUM_THREADS];
    logic [TIME_W-1:0]    ofs_tab   [NUM_THREADS];
    logic [TIME_W-1:0]    start_time;
    logic [THR_W-1:0]     active_m1;
    logic                 cfg_ok;
    logic                 wr_allow;
    logic                 arm_go;
    logic                 start_rej;
    logic [NUM_THREADS-1:0] thr_active;
    logic [NUM_THREADS-1:0] thr_en;
    logic [IDX_W-1:0]     thr_idx   [NUM_THREADS];
    logic [TIME_W-1:0]    begin_tm  [NUM_THREADS];
    logic [DUR_W-1:0]     thr_dur   [NUM_THREADS];

    assign wr_allow = (state_q == ENG_STOPPED) && !start_cmd;

    gse_cfg_store #(
        .NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS), .NUM_PORTS(NUM_PORTS),
        .NUM_TC(NUM_TC), .TIME_W(TIME_W), .DUR_W(DUR_W), .IDX_W(IDX_W), .THR_W(THR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow),
        .slot_we(slot_we), .slot_addr(slot_addr), .slot_dur(slot_dur),
        .slot_ports(slot_ports), .slot_block(slot_block),
        .thr_we(thr_we), .thr_sel(thr_sel), .thr_entry(thr_entry),
        .thr_end(thr_end), .thr_ofs(thr_ofs),
        .glb_we(glb_we), .glb_start_time(glb_start_time), .glb_active_m1(glb_active_m1),
        .dur_tab(dur_tab), .port_tab(port_tab), .blk_tab(blk_tab),
        .entry_tab(entry_tab), .end_tab(end_tab), .ofs_tab(ofs_tab),
        .start_time(start_time), .active_m1(active_m1), .wr_rej(wr_err)
    );

    gse_cfg_check #(
        .NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS), .TIME_W(TIME_W),
        .DUR_W(DUR_W), .IDX_W(IDX_W), .THR_W(THR_W), .MAX_DELTA(MAX_DELTA)
    ) u_check (
        .dur_tab(dur_tab), .entry_tab(entry_tab), .end_tab(end_tab),
        .ofs_tab(ofs_tab), .active_m1(active_m1), .cfg_ok(cfg_ok)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign thr_en[t]   = (t <= int'(active_m1));
        assign begin_tm[t] = start_time + ofs_tab[t];
        assign thr_dur[t]  = dur_tab[thr_idx[t]];

        gse_thread #(
            .IDX_W(IDX_W), .TIME_W(TIME_W), .DUR_W(DUR_W),
            .TICKS_PER_DELTA(TICKS_PER_DELTA)
        ) u_thr (
            .clk(clk), .rst_n(rst_n), .arm(arm_go), .halt(stop_cmd),
            .enable(thr_en[t]), .tick(tick), .now_time(now_time),
            .begin_time(begin_tm[t]), .entry_idx(entry_tab[t]),
            .end_idx(end_tab[t]), .cur_dur(thr_dur[t]),
            .active(thr_active[t]), .cur_idx(thr_idx[t])
        );
    end

    gse_gate_merge #(
        .NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS), .NUM_PORTS(NUM_PORTS),
        .NUM_TC(NUM_TC), .IDX_W(IDX_W)
    ) u_merge (
        .thr_active(thr_active), .thr_idx(thr_idx),
        .port_tab(port_tab), .blk_tab(blk_tab), .gate_open(gate_open)
    );

    // next engine state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_STOPPED: if (start_cmd && !stop_cmd && cfg_ok) state_d = ENG_ARMED;
            ENG_ARMED: begin
                if (stop_cmd)         state_d = ENG_STOPPED;
                else if (|thr_active) state_d = ENG_RUNNING;
            end
            ENG_RUNNING: if (stop_cmd) state_d = ENG_STOPPED;
            default:     state_d = ENG_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_STOPPED;
        else        state_q <= state_d;
    end

    // outputs by state
    always_comb begin
        sts_started = 1'b0;
        sts_stopped = 1'b0;
        arm_go      = 1'b0;
        start_rej   = 1'b0;
        unique case (state_q)
            ENG_STOPPED: begin
                sts_stopped = 1'b1;
                arm_go      = start_cmd && !stop_cmd && cfg_ok;
                start_rej   = start_cmd && !stop_cmd && !cfg_ok;
            end
            ENG_ARMED:   sts_started = 1'b0;
            ENG_RUNNING: sts_started = 1'b1;
            default:     sts_stopped = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_bad <= 1'b0;
        else if (arm_go)    cfg_bad <= 1'b0;
        else if (start_rej) cfg_bad <= 1'b1;
    end

    // R11
    wr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ENG_STOPPED) && (slot_we || thr_we || glb_we)) |=> wr_err);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ENG_STOPPED) |-> cfg_ok);

    // R9
    idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_active == '0) |-> (gate_open == '1));

    // R10
    stop_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (sts_stopped && !sts_started));
endmodule

// File: tb/sim_gate_sched_engine.sv
module sim_gate_sched_engine;
    localparam int CLK_PERIOD = 10;
    localparam int TPD  = 25;
    localparam int MAXD = 1000;

    logic        clk, rst_n, tick, start_cmd, stop_cmd;
    logic [31:0] now_time;
    logic        slot_we, thr_we, glb_we;
    logic [3:0]  slot_addr, thr_entry, thr_end;
    logic [9:0]  slot_dur;
    logic [3:0]  slot_ports;
    logic [7:0]  slot_block;
    logic [2:0]  thr_sel, glb_active_m1;
    logic [31:0] thr_ofs, glb_start_time;
    logic [31:0] gate_open;
    logic        sts_started, sts_stopped, wr_err, cfg_bad;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // bench-side view of the accepted configuration
    int         m_dur [16];
    logic [3:0] m_ports [16];
    logic [7:0] m_blk [16];
    int         m_entry [8];
    int         m_end [8];
    int         m_ofs [8];
    int         m_start, m_act;

    typedef struct { int v; logic [31:0] g; } exp_t;
    exp_t sb_q[$];

    gate_sched_engine u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .now_time(now_time),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .slot_we(slot_we), .slot_addr(slot_addr), .slot_dur(slot_dur),
        .slot_ports(slot_ports), .slot_block(slot_block),
        .thr_we(thr_we), .thr_sel(thr_sel), .thr_entry(thr_entry),
        .thr_end(thr_end), .thr_ofs(thr_ofs),
        .glb_we(glb_we), .glb_start_time(glb_start_time), .glb_active_m1(glb_active_m1),
        .gate_open(gate_open), .sts_started(sts_started), .sts_stopped(sts_stopped),
        .wr_err(wr_err), .cfg_bad(cfg_bad)
    );

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    initial begin
        now_time = 0;
        forever begin
            @(posedge clk);
            #1 now_time = now_time + 1;
        end
    end

    function automatic int cur_v();
        return int'(now_time) - 1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_gates(int v);
        logic [7:0]  cl [4];
        logic [31:0] r;
        for (int p = 0; p < 4; p++) cl[p] = 8'h00;
        for (int t = 0; t <= m_act; t++) begin
            int b = m_start + m_ofs[t];
            if (v >= b) begin
                int len = 0;
                int e;
                int k;
                for (int s = m_entry[t]; s <= m_end[t]; s++) len += m_dur[s] * TPD;
                e = (v - b) % len;
                k = m_entry[t];
                while (e >= m_dur[k] * TPD) begin
                    e -= m_dur[k] * TPD;
                    k++;
                end
                for (int p = 0; p < 4; p++) if (m_ports[k][p]) cl[p] |= m_blk[k];
            end
        end
        for (int p = 0; p < 4; p++) r[p*8 +: 8] = ~cl[p];
        return r;
    endfunction

    // driver side of the scoreboard
    task automatic push_window(int lo, int hi, int step);
        for (int v = lo; v <= hi; v += step) sb_q.push_back('{v, model_gates(v)});
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].v < cur_v()) begin
                exp_t m;
                m = sb_q.pop_front();
                n_chk++;
                n_err++;
                $display("FAIL R9: sample %0d missed, got %h expected %h", m.v, 32'h0, m.g);
            end
            if (sb_q.size() > 0 && sb_q[0].v == cur_v()) begin
                exp_t it;
                it = sb_q.pop_front();
                chk("R3 R4 R9 gate vector", gate_open, it.g);
            end
        end
    end

    task automatic drive_slot(int a, int d, logic [3:0] pm, logic [7:0] bm);
        @(negedge clk);
        slot_we = 1; slot_addr = 4'(a); slot_dur = 10'(d); slot_ports = pm; slot_block = bm;
        @(negedge clk);
        slot_we = 0;
    endtask

    task automatic wr_slot(int a, int d, logic [3:0] pm, logic [7:0] bm);
        drive_slot(a, d, pm, bm);
        m_dur[a] = d; m_ports[a] = pm; m_blk[a] = bm;
    endtask

    task automatic wr_thr(int t, int en, int ed, int of);
        @(negedge clk);
        thr_we = 1; thr_sel = 3'(t); thr_entry = 4'(en); thr_end = 4'(ed); thr_ofs = of;
        @(negedge clk);
        thr_we = 0;
        m_entry[t] = en; m_end[t] = ed; m_ofs[t] = of;
    endtask

    task automatic wr_glb(int st, int act);
        @(negedge clk);
        glb_we = 1; glb_start_time = st; glb_active_m1 = 3'(act);
        @(negedge clk);
        glb_we = 0;
        m_start = st; m_act = act;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_cmd = 1;
        @(negedge clk); start_cmd = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_cmd = 1;
        @(negedge clk); stop_cmd = 0;
    endtask

    task automatic wait_v(int target);
        while (cur_v() < target) @(negedge clk);
    endtask

    task automatic expect_reject(string req);
        pulse_start();
        chk({req, " cfg_bad"}, 32'(cfg_bad), 32'd1);
        chk({req, " stays stopped"}, 32'(sts_stopped), 32'd1);
        repeat (3) @(negedge clk);
        chk({req, " gates open"}, gate_open, 32'hFFFF_FFFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int s1, s2;
        logic [31:0] held;
        rst_n = 0; tick = 1; start_cmd = 0; stop_cmd = 0;
        slot_we = 0; thr_we = 0; glb_we = 0;
        slot_addr = 0; slot_dur = 0; slot_ports = 0; slot_block = 0;
        thr_sel = 0; thr_entry = 0; thr_end = 0; thr_ofs = 0;
        glb_start_time = 0; glb_active_m1 = 0;
        for (int i = 0; i < 16; i++) begin m_dur[i] = 0; m_ports[i] = 0; m_blk[i] = 0; end
        for (int i = 0; i < 8; i++) begin m_entry[i] = 0; m_end[i] = 0; m_ofs[i] = 0; end
        m_start = 0; m_act = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 gates", gate_open, 32'hFFFF_FFFF);
        chk("R1 stopped", 32'(sts_stopped), 32'd1);
        chk("R1 started", 32'(sts_started), 32'd0);
        chk("R1 wr_err", 32'(wr_err), 32'd0);
        chk("R1 cfg_bad", 32'(cfg_bad), 32'd0);

        // two threads; R2: threads 2..7 have zero offset but are unused
        wr_slot(0, 1, 4'b0001, 8'h0F);
        wr_slot(1, 2, 4'b0001, 8'hF0);
        wr_slot(2, 1, 4'b0011, 8'h11);
        wr_slot(3, 2, 4'b0010, 8'h81);
        wr_slot(4, 1, 4'b0110, 8'h3C);
        chk("R11 accepted write", 32'(wr_err), 32'd0);
        wr_thr(0, 0, 2, 1);
        wr_thr(1, 3, 4, 40);
        for (int t = 2; t < 8; t++) wr_thr(t, 0, 4, 0);
        s1 = int'(now_time) + 60;
        wr_glb(s1, 1);
        push_window(s1 - 5, s1 + 420, 5);
        pulse_start();
        chk("R2 start accepted", 32'(cfg_bad), 32'd0);
        chk("R10 armed started", 32'(sts_started), 32'd0);
        chk("R10 armed stopped", 32'(sts_stopped), 32'd0);
        wait_v(s1 + 1);
        chk("R10 started lag", 32'(sts_started), 32'd0);
        wait_v(s1 + 2);
        chk("R10 started", 32'(sts_started), 32'd1);

        // R11: write while running is refused and has no effect on gates
        wait_v(s1 + 200);
        drive_slot(0, 3, 4'hF, 8'hFF);
        chk("R11 wr_err pulse", 32'(wr_err), 32'd1);
        @(negedge clk);
        chk("R11 wr_err clears", 32'(wr_err), 32'd0);

        wait_v(s1 + 425);
        pulse_stop();
        chk("R10 stop stopped", 32'(sts_stopped), 32'd1);
        chk("R10 stop started", 32'(sts_started), 32'd0);
        chk("R10 stop gates", gate_open, 32'hFFFF_FFFF);

        // R6
        wr_thr(1, 3, 4, 0);
        expect_reject("R6");
        wr_thr(1, 3, 4, 40);
        // R7
        wr_slot(4, 0, 4'b0110, 8'h3C);
        expect_reject("R7 zero");
        wr_slot(3, MAXD, 4'b0010, 8'h81);
        expect_reject("R7 long");
        wr_slot(4, 1, 4'b0110, 8'h3C);
        wr_slot(3, 2, 4'b0010, 8'h81);
        // R8
        wr_thr(2, 0, 3, 0);
        expect_reject("R8 order");
        wr_thr(2, 0, 4, 0);
        wr_thr(1, 4, 3, 40);
        expect_reject("R8 entry");
        wr_thr(1, 3, 4, 40);

        // R12: accepted start clears cfg_bad
        s2 = int'(now_time) + 50;
        wr_glb(s2, 1);
        push_window(s2, s2 + 150, 5);
        pulse_start();
        chk("R12 cfg_bad cleared", 32'(cfg_bad), 32'd0);
        chk("R12 running path", 32'(sts_stopped), 32'd0);
        wait_v(s2 + 160);

        // R5: tick low holds the slot
        @(negedge clk);
        tick = 0;
        held = gate_open;
        repeat (80) begin
            @(negedge clk);
            chk("R5 stall hold", gate_open, held);
        end
        tick = 1;
        pulse_stop();
        chk("R10 final stop", 32'(sts_stopped), 32'd1);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule